// File: doc/BRIEF.md
# Page-One Hardware Stack Controller

This block holds the 8-bit stack pointer of a small 8-bit processor and turns stack commands into byte accesses on a simple synchronous memory. The stack lives in one fixed 256-byte page, with the page number as a parameter (default 0x01). The pointer therefore selects only the low address byte. A push writes at the current pointer and then moves the pointer down. A pull moves the pointer up first and then reads there. The pointer wraps within 8 bits in both directions and raises no overflow or underflow indication.

The block takes eight one-hot commands:
- push the accumulator or the status register;
- pull the accumulator or the status register;
- copy the pointer into the index register, or the index register into the pointer;
- save a 16-bit return address for a subroutine call;
- restore that address on return.

The status register sits inside the block. The accumulator, index register and program counter belong to the surrounding core: the block hands them a byte or a 16-bit value together with a write strobe. The memory returns read data one cycle after a read strobe.

Top module: `stkpg_ctrl`

## Requirements
- R1: Every write goes to address {STACK_PAGE, SP}. Every read goes to {STACK_PAGE, SP+1 mod 256}, where SP is the pointer value shown on sp_o in that cycle.
- R2: op_i = 0x01 pushes acc_i and op_i = 0x02 pushes the status register. Either one makes a single write in the accepting cycle with done_o high and busy_o low. sp_o is one lower after that edge.
- R3: op_i = 0x04 pulls into the accumulator and op_i = 0x08 pulls into the status register. The accepting cycle issues the read and sp_o is one higher after that edge. In the next cycle busy_o and done_o are high. For the accumulator, load_data_o carries the read byte and acc_we_o is high in that cycle. For the status register, stat_o shows the read byte from the following cycle.
- R4: op_i = 0x10 raises idx_we_o with load_data_o equal to SP for one cycle and leaves SP unchanged. op_i = 0x20 loads idx_i into SP. Neither command makes a memory access.
- R5: op_i = 0x40 writes ret_addr_i[15:8] at SP in the accepting cycle. In the next cycle (busy_o and done_o high) it writes the low byte of ret_addr_i, as it was when the command was accepted, at the decremented SP. SP ends two lower.
- R6: op_i = 0x80 reads at SP+1 and then at the new SP+1, one read per cycle. In the third cycle pc_we_o and done_o are high and pc_o = {second byte read, first byte read}. SP ends two higher.
- R7: SP wraps modulo 256: a push at 0x00 leaves 0xFF and a pull at 0xFF reads 0x00. The address page never changes.
- R8: While rst is high at a clock edge, SP returns to SP_INIT (default 0xFF) and the status register returns to STAT_INIT. After that edge busy_o, done_o and both memory strobes are low.
- R9: A command presented while busy_o is high has no effect. An op_i with no bit set, or with more than one bit set, also has no effect.
- R10: The write and read strobes are never high together, and the cycle after done_o is never busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 8 | One-hot command |
| acc_i | input | 8 | Accumulator value for a push |
| idx_i | input | 8 | Index register value for loading SP |
| ret_addr_i | input | 16 | Return address to save on a call |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | A two-cycle or three-cycle sequence is in its later cycles |
| done_o | output | 1 | Final cycle of a command |
| sp_o | output | 8 | Current stack pointer |
| stat_o | output | 8 | Status register |
| mem_addr_o | output | 16 | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| load_data_o | output | 8 | Byte for the accumulator or index register |
| acc_we_o | output | 1 | Accumulator load strobe |
| idx_we_o | output | 1 | Index register load strobe |
| pc_o | output | 16 | Restored return address |
| pc_we_o | output | 1 | Program counter load strobe |

## Verification
The assertions assume only a synchronous reset. They relate the strobes to the pointer movement they cause and to the address page, so they hold for any op_i pattern, malformed ones included. The stimulus presents well-formed one-hot commands in idle cycles and feeds in malformed words and commands during busy cycles on purpose. A bench-side byte memory answers reads one cycle late, as the block expects. Sweeping the pointer through all 256 values exercises the wrap points for single-byte pairs and for two-byte call/return pairs.

// File: rtl/stkpg_pkg.sv
package stkpg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int OP_W   = 8;

    // one-hot command bit positions
    localparam int OP_PUSH_ACC  = 0;
    localparam int OP_PUSH_STAT = 1;
    localparam int OP_PULL_ACC  = 2;
    localparam int OP_PULL_STAT = 3;
    localparam int OP_SP_TO_IDX = 4;
    localparam int OP_IDX_TO_SP = 5;
    localparam int OP_CALL      = 6;
    localparam int OP_RET       = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULL_DATA,
        SQ_CALL_LO,
        SQ_RET_HI,
        SQ_RET_END
    } seq_st_e;

    typedef enum logic [1:0] {
        SPA_HOLD,
        SPA_INC,
        SPA_DEC,
        SPA_LOAD
    } sp_act_e;

    typedef enum logic [1:0] {
        WS_ACC,
        WS_STAT,
        WS_RET_HI,
        WS_HELD
    } wsel_e;

    typedef struct packed {
        sp_act_e sp_act;
        logic    mem_we;
        logic    mem_re;
        wsel_e   wsel;
        logic    hold_lo;
        logic    cap_rd;
        logic    acc_we;
        logic    stat_we;
        logic    idx_we;
        logic    pc_we;
        logic    done;
    } seq_ctl_t;

    function automatic logic [ADDR_W-1:0] page_addr(input byte_t page, input byte_t off);
        return {page, off};
    endfunction

    function automatic logic single_cmd(input logic [OP_W-1:0] v);
        return $countones(v) == 1;
    endfunction

endpackage

// File: rtl/stkpg_seq.sv
module stkpg_seq
    import stkpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    output seq_ctl_t        ctl_o,
    output logic            busy_o
);

    seq_st_e st_q, st_d;
    logic    pull_stat_q, pull_stat_d;

    always_comb begin
        ctl_o       = '0;
        ctl_o.sp_act = SPA_HOLD;
        ctl_o.wsel   = WS_ACC;
        st_d        = st_q;
        pull_stat_d = pull_stat_q;
        case (st_q)
            SQ_IDLE: begin
                if (single_cmd(op_i)) begin
                    if (op_i[OP_PUSH_ACC]) begin
                        ctl_o.mem_we = 1'b1;
                        ctl_o.sp_act = SPA_DEC;
                        ctl_o.wsel   = WS_ACC;
                        ctl_o.done   = 1'b1;
                    end
                    if (op_i[OP_PUSH_STAT]) begin
                        ctl_o.mem_we = 1'b1;
                        ctl_o.sp_act = SPA_DEC;
                        ctl_o.wsel   = WS_STAT;
                        ctl_o.done   = 1'b1;
                    end
                    if (op_i[OP_PULL_ACC] || op_i[OP_PULL_STAT]) begin
                        ctl_o.mem_re = 1'b1;
                        ctl_o.sp_act = SPA_INC;
                        st_d         = SQ_PULL_DATA;
                        pull_stat_d  = op_i[OP_PULL_STAT];
                    end
                    if (op_i[OP_SP_TO_IDX]) begin
                        ctl_o.idx_we = 1'b1;
                        ctl_o.done   = 1'b1;
                    end
                    if (op_i[OP_IDX_TO_SP]) begin
                        ctl_o.sp_act = SPA_LOAD;
                        ctl_o.done   = 1'b1;
                    end
                    if (op_i[OP_CALL]) begin
                        ctl_o.mem_we  = 1'b1;
                        ctl_o.sp_act  = SPA_DEC;
                        ctl_o.wsel    = WS_RET_HI;
                        ctl_o.hold_lo = 1'b1;
                        st_d          = SQ_CALL_LO;
                    end
                    if (op_i[OP_RET]) begin
                        ctl_o.mem_re = 1'b1;
                        ctl_o.sp_act = SPA_INC;
                        st_d         = SQ_RET_HI;
                    end
                end
            end
            SQ_PULL_DATA: begin
                ctl_o.acc_we  = !pull_stat_q;
                ctl_o.stat_we = pull_stat_q;
                ctl_o.done    = 1'b1;
                st_d          = SQ_IDLE;
            end
            SQ_CALL_LO: begin
                ctl_o.mem_we = 1'b1;
                ctl_o.sp_act = SPA_DEC;
                ctl_o.wsel   = WS_HELD;
                ctl_o.done   = 1'b1;
                st_d         = SQ_IDLE;
            end
            SQ_RET_HI: begin
                ctl_o.mem_re = 1'b1;
                ctl_o.sp_act = SPA_INC;
                ctl_o.cap_rd = 1'b1;
                st_d         = SQ_RET_END;
            end
            SQ_RET_END: begin
                ctl_o.pc_we = 1'b1;
                ctl_o.done  = 1'b1;
                st_d        = SQ_IDLE;
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SQ_IDLE;
            pull_stat_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            pull_stat_q <= pull_stat_d;
        end
    end

    assign busy_o = (st_q != SQ_IDLE);

    AST_BUSY_NO_NEW_READ: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_PULL_DATA) |-> !ctl_o.mem_re && !ctl_o.mem_we) else $error("AST_BUSY_NO_NEW_READ"); // R9

endmodule

// File: rtl/stkpg_sp.sv
module stkpg_sp
    import stkpg_pkg::*;
#(
    parameter byte_t SP_INIT = 8'hFF
) (
    input  logic    clk,
    input  logic    rst,
    input  sp_act_e act_i,
    input  byte_t   load_i,
    output byte_t   sp_o,
    output byte_t   sp_inc_o
);

    byte_t sp_q;
    byte_t sp_dec;

    assign sp_inc_o = sp_q + byte_t'(1);
    assign sp_dec   = sp_q - byte_t'(1);
    assign sp_o     = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_INIT;
        end else begin
            case (act_i)
                SPA_INC:  sp_q <= sp_inc_o;
                SPA_DEC:  sp_q <= sp_dec;
                SPA_LOAD: sp_q <= load_i;
                default:  sp_q <= sp_q;
            endcase
        end
    end

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (act_i == SPA_DEC && sp_q == '0) |=> (sp_q == '1)) else $error("AST_WRAP_DOWN"); // R7
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (act_i == SPA_INC && sp_q == '1) |=> (sp_q == '0)) else $error("AST_WRAP_UP"); // R7

endmodule

// File: rtl/stkpg_dpath.sv
module stkpg_dpath
    import stkpg_pkg::*;
#(
    parameter byte_t STAT_INIT  = 8'h20,
    parameter byte_t STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl_i,
    input  byte_t             sp_i,
    input  byte_t             sp_inc_i,
    input  byte_t             acc_i,
    input  logic [ADDR_W-1:0] ret_addr_i,
    input  byte_t             rd_i,
    output logic [ADDR_W-1:0] addr_o,
    output byte_t             wdata_o,
    output byte_t             load_o,
    output byte_t             stat_o,
    output logic [ADDR_W-1:0] pc_o
);

    byte_t stat_q;
    byte_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_INIT;
            held_q <= '0;
        end else begin
            if (ctl_i.stat_we) stat_q <= rd_i;
            if (ctl_i.hold_lo)     held_q <= ret_addr_i[BYTE_W-1:0];
            else if (ctl_i.cap_rd) held_q <= rd_i;
        end
    end

    always_comb begin
        addr_o = page_addr(STACK_PAGE, ctl_i.mem_re ? sp_inc_i : sp_i);
        case (ctl_i.wsel)
            WS_ACC:    wdata_o = acc_i;
            WS_STAT:   wdata_o = stat_q;
            WS_RET_HI: wdata_o = ret_addr_i[ADDR_W-1:BYTE_W];
            default:   wdata_o = held_q;
        endcase
        load_o = ctl_i.idx_we ? sp_i : rd_i;
        pc_o   = {rd_i, held_q};
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/stkpg_ctrl.sv
module stkpg_ctrl
    import stkpg_pkg::*;
#(
    parameter logic [7:0] SP_INIT    = 8'hFF,
    parameter logic [7:0] STAT_INIT  = 8'h20,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  op_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  idx_i,
    input  logic [15:0] ret_addr_i,
    input  logic [7:0]  mem_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [7:0]  sp_o,
    output logic [7:0]  stat_o,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        mem_we_o,
    output logic        mem_re_o,
    output logic [7:0]  load_data_o,
    output logic        acc_we_o,
    output logic        idx_we_o,
    output logic [15:0] pc_o,
    output logic        pc_we_o
);

    seq_ctl_t ctl;
    byte_t    sp_cur;
    byte_t    sp_nxt_up;

    stkpg_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op_i),
        .ctl_o  (ctl),
        .busy_o (busy_o)
    );

    stkpg_sp #(.SP_INIT(SP_INIT)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .act_i    (ctl.sp_act),
        .load_i   (idx_i),
        .sp_o     (sp_cur),
        .sp_inc_o (sp_nxt_up)
    );

    stkpg_dpath #(.STAT_INIT(STAT_INIT), .STACK_PAGE(STACK_PAGE)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .sp_i       (sp_cur),
        .sp_inc_i   (sp_nxt_up),
        .acc_i      (acc_i),
        .ret_addr_i (ret_addr_i),
        .rd_i       (mem_rdata_i),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .load_o     (load_data_o),
        .stat_o     (stat_o),
        .pc_o       (pc_o)
    );

    assign sp_o     = sp_cur;
    assign done_o   = ctl.done;
    assign mem_we_o = ctl.mem_we;
    assign mem_re_o = ctl.mem_re;
    assign acc_we_o = ctl.acc_we;
    assign idx_we_o = ctl.idx_we;
    assign pc_we_o  = ctl.pc_we;

    AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (mem_addr_o == {STACK_PAGE, sp_o})) else $error("AST_WRITE_ADDR"); // R1
    AST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> (mem_addr_o == {STACK_PAGE, sp_o + 8'd1})) else $error("AST_READ_ADDR"); // R1
    AST_WRITE_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> (sp_o == $past(sp_o) - 8'd1)) else $error("AST_WRITE_STEPS_DOWN"); // R2
    AST_READ_STEPS_UP: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |=> (sp_o == $past(sp_o) + 8'd1)) else $error("AST_READ_STEPS_UP"); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_we_o && mem_re_o)) else $error("AST_STROBE_EXCL"); // R10
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o) else $error("AST_DONE_RELEASES"); // R10
    AST_PC_LAST: assert property (@(posedge clk) disable iff (rst)
        pc_we_o |-> $past(mem_re_o) && busy_o) else $error("AST_PC_LAST"); // R6

endmodule

// File: tb/sim_stkpg_ctrl.sv
module sim_stkpg_ctrl;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] PAGE       = 8'h01;
    localparam logic [7:0] SP_RST     = 8'hFF;
    localparam logic [7:0] ST_RST     = 8'h34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op  = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  idx = '0;
    logic [15:0] ret = '0;
    logic [7:0]  rdata = '0;

    logic        busy, done, we, re, acc_we, idx_we, pc_we;
    logic [7:0]  sp, stat, wdata, ldata;
    logic [15:0] addr, pc;

    logic [7:0]  mem [256];
    logic [7:0]  msp;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (we) mem[addr[7:0]] <= wdata;
        if (re) rdata <= mem[addr[7:0]];
    end

    stkpg_ctrl #(.SP_INIT(SP_RST), .STAT_INIT(ST_RST), .STACK_PAGE(PAGE)) u0 (
        .clk(clk), .rst(rst), .op_i(op), .acc_i(acc), .idx_i(idx), .ret_addr_i(ret),
        .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .sp_o(sp), .stat_o(stat),
        .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
        .load_data_o(ldata), .acc_we_o(acc_we), .idx_we_o(idx_we), .pc_o(pc), .pc_we_o(pc_we)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_acc(input logic [7:0] v);
        @(negedge clk); acc = v; op = 8'h01; #1;
        expect_eq("R2", "push write strobe", 32'(we), 32'd1);
        expect_eq("R10", "push read strobe", 32'(re), 32'd0);
        expect_eq("R1", "push address", 32'(addr), 32'({PAGE, msp}));
        expect_eq("R2", "push data", 32'(wdata), 32'(v));
        expect_eq("R2", "push done", 32'(done), 32'd1);
        expect_eq("R2", "push busy", 32'(busy), 32'd0);
        @(negedge clk); op = '0; msp = msp - 8'd1; #1;
        expect_eq("R7", "sp after push", 32'(sp), 32'(msp));
    endtask

    task automatic push_stat(input logic [7:0] v);
        @(negedge clk); op = 8'h02; #1;
        expect_eq("R2", "status push strobe", 32'(we), 32'd1);
        expect_eq("R2", "status push data", 32'(wdata), 32'(v));
        expect_eq("R1", "status push address", 32'(addr), 32'({PAGE, msp}));
        @(negedge clk); op = '0; msp = msp - 8'd1; #1;
        expect_eq("R2", "sp after status push", 32'(sp), 32'(msp));
    endtask

    task automatic pull(input bit to_stat, input logic [7:0] v);
        @(negedge clk); op = to_stat ? 8'h08 : 8'h04; #1;
        expect_eq("R3", "pull read strobe", 32'(re), 32'd1);
        expect_eq("R10", "pull write strobe", 32'(we), 32'd0);
        expect_eq("R1", "pull address", 32'(addr), 32'({PAGE, msp + 8'd1}));
        expect_eq("R3", "pull first done", 32'(done), 32'd0);
        @(negedge clk); op = '0; msp = msp + 8'd1; #1;
        expect_eq("R3", "pull busy", 32'(busy), 32'd1);
        expect_eq("R3", "pull done", 32'(done), 32'd1);
        expect_eq("R7", "sp after pull", 32'(sp), 32'(msp));
        expect_eq("R3", "acc strobe", 32'(acc_we), 32'(!to_stat));
        if (!to_stat) begin
            expect_eq("R3", "pulled byte", 32'(ldata), 32'(v));
        end else begin
            @(negedge clk); #1;
            expect_eq("R3", "status after pull", 32'(stat), 32'(v));
        end
    endtask

    task automatic sp_to_idx();
        @(negedge clk); op = 8'h10; #1;
        expect_eq("R4", "index strobe", 32'(idx_we), 32'd1);
        expect_eq("R4", "index value", 32'(ldata), 32'(msp));
        expect_eq("R4", "copy done", 32'(done), 32'd1);
        expect_eq("R4", "copy no access", 32'({we, re}), 32'd0);
        @(negedge clk); op = '0; #1;
        expect_eq("R4", "sp kept", 32'(sp), 32'(msp));
    endtask

    task automatic idx_to_sp(input logic [7:0] v);
        @(negedge clk); idx = v; op = 8'h20; #1;
        expect_eq("R4", "load no access", 32'({we, re, idx_we}), 32'd0);
        expect_eq("R4", "load done", 32'(done), 32'd1);
        @(negedge clk); op = '0; msp = v; #1;
        expect_eq("R4", "sp loaded", 32'(sp), 32'(v));
    endtask

    task automatic call(input logic [15:0] r, input bit inject);
        @(negedge clk); ret = r; op = 8'h40; #1;
        expect_eq("R5", "call high strobe", 32'(we), 32'd1);
        expect_eq("R5", "call high address", 32'(addr), 32'({PAGE, msp}));
        expect_eq("R5", "call high byte", 32'(wdata), 32'(r[15:8]));
        expect_eq("R5", "call first busy", 32'(busy), 32'd0);
        @(negedge clk); msp = msp - 8'd1; ret = ~r; idx = 8'h11;
        op = inject ? 8'h20 : 8'h00; #1;
        expect_eq("R5", "call low strobe", 32'(we), 32'd1);
        expect_eq("R7", "call low address", 32'(addr), 32'({PAGE, msp}));
        expect_eq("R5", "call low byte", 32'(wdata), 32'(r[7:0]));
        expect_eq("R5", "call busy", 32'(busy), 32'd1);
        expect_eq("R5", "call done", 32'(done), 32'd1);
        @(negedge clk); op = '0; msp = msp - 8'd1; #1;
        expect_eq(inject ? "R9" : "R5", "sp after call", 32'(sp), 32'(msp));
        expect_eq("R10", "idle after call", 32'(busy), 32'd0);
    endtask

    task automatic ret_pop(input logic [15:0] r, input bit inject);
        @(negedge clk); op = 8'h80; #1;
        expect_eq("R6", "return first read", 32'(re), 32'd1);
        expect_eq("R1", "return first address", 32'(addr), 32'({PAGE, msp + 8'd1}));
        @(negedge clk); acc = 8'hEE; op = inject ? 8'h01 : 8'h00; msp = msp + 8'd1; #1;
        expect_eq("R6", "return second read", 32'(re), 32'd1);
        expect_eq(inject ? "R9" : "R6", "no write while busy", 32'(we), 32'd0);
        expect_eq("R7", "return second address", 32'(addr), 32'({PAGE, msp + 8'd1}));
        expect_eq("R6", "return busy", 32'(busy), 32'd1);
        expect_eq("R6", "return not done", 32'(done), 32'd0);
        @(negedge clk); op = inject ? 8'h10 : 8'h00; msp = msp + 8'd1; #1;
        expect_eq("R6", "pc strobe", 32'(pc_we), 32'd1);
        expect_eq("R6", "pc value", 32'(pc), 32'(r));
        expect_eq("R6", "return done", 32'(done), 32'd1);
        expect_eq(inject ? "R9" : "R6", "no index copy while busy", 32'(idx_we), 32'd0);
        @(negedge clk); op = '0; #1;
        expect_eq("R6", "sp after return", 32'(sp), 32'(msp));
        expect_eq("R10", "idle after return", 32'(busy), 32'd0);
    endtask

    task automatic bad_op(input logic [7:0] v);
        @(negedge clk); idx = 8'h5C; acc = 8'h77; op = v; #1;
        expect_eq("R9", "malformed op strobes", 32'({we, re, done, idx_we, acc_we, pc_we}), 32'd0);
        @(negedge clk); op = '0; #1;
        expect_eq("R9", "malformed op sp", 32'(sp), 32'(msp));
        expect_eq("R9", "malformed op busy", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        msp = SP_RST;
        repeat (3) @(negedge clk);
        rst = 1'b0; #1;
        expect_eq("R8", "reset sp", 32'(sp), 32'(SP_RST));
        expect_eq("R8", "reset status", 32'(stat), 32'(ST_RST));
        expect_eq("R8", "reset outputs", 32'({busy, done, we, re}), 32'd0);

        push_stat(ST_RST);
        push_acc(8'hC3);
        pull(1'b1, 8'hC3);
        pull(1'b0, ST_RST);

        for (int v = 0; v < 256; v++) begin
            idx_to_sp(8'(v));
            push_acc(8'(v) ^ 8'h5A);
            pull(1'b0, 8'(v) ^ 8'h5A);
        end

        for (int v = 0; v < 256; v++) begin
            idx_to_sp(8'(v));
            call({8'(v) ^ 8'hA5, 8'(v)}, v[0]);
            ret_pop({8'(v) ^ 8'hA5, 8'(v)}, v[1]);
        end

        for (int v = 0; v < 16; v++) begin
            idx_to_sp(8'(v * 17));
            sp_to_idx();
        end

        bad_op(8'h00);
        bad_op(8'h03);
        bad_op(8'hC0);
        bad_op(8'hFF);

        push_acc(8'h99);
        pull(1'b1, 8'h99);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; msp = SP_RST; #1;
        expect_eq("R8", "sp after late reset", 32'(sp), 32'(SP_RST));
        expect_eq("R8", "status after late reset", 32'(stat), 32'(ST_RST));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule